// File: doc/BRIEF.md
# Serial ADC Power-Mode Sequencer

This block is the digital control core of a serial successive-approximation converter. It watches the converter's active-low chip-select and its serial clock, and tracks the converter's power state from where chip-select rises. It counts the serial-clock falling edges in every frame that chip-select holds low. It then decides whether the frame was a normal conversion, a request to power down, or a dummy frame that wakes the part. Short chip-select pulses are rejected, so that a glitch cannot power the part down or wake it by accident.

Both pins are sampled by a faster system clock through synchronizers, and all edge detection runs in the system clock domain. The block drives a power enable for the analog section and an output enable for the three-state serial data line. It also drives a flag that marks frames whose result can be trusted. The serial data bit is a stand-in: each frame carries a 16-bit tag that counts the valid frames, so that a bench can tell frames apart. No conversion result is modelled.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset the part is fully powered (pwr_en_o=1), the data line is released (sdo_oe_o=0) and data_valid_o=0.
- R2: A synchronized falling edge of cs_ni opens a frame and clears the edge count. Each synchronized falling edge of sclk_i inside the frame adds one to the count, which saturates at 31 and never wraps.
- R3: When the part is fully powered and cs_ni rises with fewer than 2 counted edges, the part stays fully powered.
- R4: When the part is fully powered and cs_ni rises with 2 to 9 counted edges, the frame is aborted and the part powers down: pwr_en_o=0 and sdo_oe_o=0.
- R5: When the part is fully powered and cs_ni rises with 10 or more counted edges, the part stays fully powered.
- R6: sdo_oe_o is 1 only while a frame is open and is 0 whenever pwr_en_o is 0.
- R7: When the part is powered down, a cs_ni fall sets pwr_en_o to 1 for that frame. If cs_ni rises with fewer than 10 counted edges, pwr_en_o returns to 0.
- R8: A wake frame whose count reaches 16 leaves the part fully powered when cs_ni rises. A wake frame that ends with 10 to 15 edges keeps pwr_en_o=1, but the next frame is still a wake frame.
- R9: data_valid_o is 1 during a frame only if that frame began while the part was fully powered. It is 0 in every wake frame.
- R10: In a valid frame, while the count c is from 4 to 19, sdo_o carries bit 19-c of the frame tag, so the tag goes out most significant bit first. At all other times sdo_o is 0. The tag equals the number of valid frames that began earlier since reset, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than sclk_i |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip-select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| pwr_en_o | output | 1 | Analog power enable |
| sdo_oe_o | output | 1 | Output enable for the serial data line |
| sdo_o | output | 1 | Serial data stand-in bit |
| data_valid_o | output | 1 | Current frame carries a valid result |

## Verification
The hardest state to reach is a wake frame that passes the tenth edge but ends before the sixteenth. The part is then powered, but the next frame must still be treated as a wake frame and marked invalid. To get there, the stimulus first powers the part down with an aborted frame, then sends a 12-edge frame, and then a full 20-edge frame whose valid flag is checked. A 34-edge frame checks that the count saturates: if the count wrapped, the rise would look like an abort at count 2.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  typedef enum logic [1:0] {
    PM_ON    = 2'd0,  // fully powered
    PM_OFF   = 2'd1,  // powered down
    PM_WAKE  = 2'd2,  // wake frame in progress or wake not complete
    PM_ARMED = 2'd3   // wake complete inside current frame
  } pm_state_e;
endpackage

// File: rtl/adc_pwr_sync.sv
module adc_pwr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {(STAGES+1){RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/adc_pwr_frame.sv
module adc_pwr_frame #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_fall_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             open_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      open_o <= 1'b0;
    end else begin
      if (cs_fall_i)      open_o <= 1'b1;
      else if (cs_rise_i) open_o <= 1'b0;
      if (cs_fall_i)
        cnt_o <= '0;
      else if (sclk_fall_i && open_o && cnt_o != CntMax)
        cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
  import adc_pwr_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int DOWN_LO  = 2,
  parameter int DOWN_HI  = 10,
  parameter int WAKE_MIN = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  output pm_state_e        state_o
);
  localparam logic [CNT_W-1:0] Lo   = CNT_W'(DOWN_LO);
  localparam logic [CNT_W-1:0] Hi   = CNT_W'(DOWN_HI);
  localparam logic [CNT_W-1:0] Full = CNT_W'(WAKE_MIN);

  pm_state_e state_d;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      PM_ON:    if (cs_rise_i && cnt_i >= Lo && cnt_i < Hi) state_d = PM_OFF;
      PM_OFF:   if (cs_fall_i) state_d = PM_WAKE;
      PM_WAKE: begin
        if (cs_rise_i) begin
          if (cnt_i < Hi)         state_d = PM_OFF;
          else if (cnt_i >= Full) state_d = PM_ON;
        end else if (cnt_i >= Full) begin
          state_d = PM_ARMED;
        end
      end
      PM_ARMED: if (cs_rise_i) state_d = PM_ON;
      default:  state_d = PM_ON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= PM_ON;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/adc_pwr_sdo.sv
module adc_pwr_sdo
  import adc_pwr_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int DATA_W = 16,
  parameter int LEAD   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  pm_state_e        state_i,
  output logic             valid_o,
  output logic             sdo_o
);
  localparam logic [CNT_W-1:0] First = CNT_W'(LEAD);
  localparam logic [CNT_W-1:0] Last  = CNT_W'(LEAD + DATA_W);

  logic [DATA_W-1:0] tag_q, word_q, shifted;
  logic [CNT_W-1:0]  offs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q   <= '0;
      word_q  <= '0;
      valid_o <= 1'b0;
    end else if (cs_fall_i) begin
      valid_o <= (state_i == PM_ON);
      if (state_i == PM_ON) begin
        word_q <= tag_q;
        tag_q  <= tag_q + 1'b1;
      end
    end else if (cs_rise_i) begin
      valid_o <= 1'b0;
    end
  end

  assign offs    = cnt_i - First;
  assign shifted = word_q << offs;
  assign sdo_o   = valid_o && cnt_i >= First && cnt_i < Last && shifted[DATA_W-1];
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5,
  parameter int DOWN_LO     = 2,
  parameter int DOWN_HI     = 10,
  parameter int WAKE_MIN    = 16,
  parameter int DATA_W      = 16,
  parameter int LEAD        = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic pwr_en_o,
  output logic sdo_oe_o,
  output logic sdo_o,
  output logic data_valid_o
);
  logic             cs_lvl, cs_rise, cs_fall;
  logic             sclk_lvl, sclk_rise, sclk_fall;
  logic [CNT_W-1:0] cnt_q;
  logic             frame_open;
  pm_state_e        state_q;

  adc_pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk_i, .rst_ni, .d_i(cs_ni),
    .lvl_o(cs_lvl), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  adc_pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
    .clk_i, .rst_ni, .d_i(sclk_i),
    .lvl_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  adc_pwr_frame #(.CNT_W(CNT_W)) u_frame (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .sclk_fall_i(sclk_fall),
    .cnt_o(cnt_q), .open_o(frame_open)
  );

  adc_pwr_fsm #(
    .CNT_W(CNT_W), .DOWN_LO(DOWN_LO), .DOWN_HI(DOWN_HI), .WAKE_MIN(WAKE_MIN)
  ) u_fsm (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .cnt_i(cnt_q),
    .state_o(state_q)
  );

  adc_pwr_sdo #(.CNT_W(CNT_W), .DATA_W(DATA_W), .LEAD(LEAD)) u_sdo (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .cnt_i(cnt_q),
    .state_i(state_q), .valid_o(data_valid_o), .sdo_o(sdo_o)
  );

  logic unused_lvls;
  assign unused_lvls = cs_lvl ^ sclk_lvl ^ sclk_rise;

  assign pwr_en_o = (state_q != PM_OFF);
  assign sdo_oe_o = frame_open && pwr_en_o;
endmodule

// File: rtl/adc_pwr_chk.sv
module adc_pwr_chk
  import adc_pwr_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_fall,
  input logic             cs_rise,
  input logic [CNT_W-1:0] cnt_q,
  input pm_state_e        state_q,
  input logic             pwr_en_o,
  input logic             sdo_oe_o,
  input logic             data_valid_o
);
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> cnt_q <= CNT_W'(1));  // R2
  AST_GLITCH_STAYS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && state_q == PM_ON && cnt_q < CNT_W'(2)) |=> pwr_en_o);  // R3
  AST_ABORT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && state_q == PM_ON && cnt_q >= CNT_W'(2) && cnt_q < CNT_W'(10))
      |=> (!pwr_en_o && !sdo_oe_o));  // R4
  AST_FULL_STAYS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && state_q == PM_ON && cnt_q >= CNT_W'(10)) |=> pwr_en_o);  // R5
  AST_OE_NEEDS_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> !sdo_oe_o);  // R6
  AST_WAKE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_fall && state_q == PM_OFF) |=> pwr_en_o);  // R7
  AST_WAKE_GLITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && state_q == PM_WAKE && cnt_q < CNT_W'(10)) |=> !pwr_en_o);  // R7
  AST_VALID_NEEDS_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> pwr_en_o);  // R9
  AST_WAKE_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_fall && state_q != PM_ON) |=> !data_valid_o);  // R9
endmodule

bind adc_pwr_seq adc_pwr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .cnt_q(cnt_q), .state_q(state_q), .pwr_en_o(pwr_en_o),
  .sdo_oe_o(sdo_oe_o), .data_valid_o(data_valid_o)
);

// File: tb/sim_adc_pwr_seq.sv
module sim_adc_pwr_seq;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1;
  logic sclk_i = 1'b1;
  logic pwr_en_o, sdo_oe_o, sdo_o, data_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  int tag = 0;
  localparam int Half = 8;

  always #10 clk_i = ~clk_i;  // 50 MHz

  adc_pwr_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i),
    .pwr_en_o(pwr_en_o), .sdo_oe_o(sdo_oe_o), .sdo_o(sdo_o),
    .data_valid_o(data_valid_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one CS-low frame with n serial clock pulses
  task automatic frame(input int n, output logic pwr_mid, output logic oe_mid,
                       output logic vld_mid, output logic [15:0] word);
    word = '0;
    cs_ni = 1'b0;
    tick(Half);
    pwr_mid = pwr_en_o;
    oe_mid  = sdo_oe_o;
    vld_mid = data_valid_o;
    for (int k = 1; k <= n; k++) begin
      sclk_i = 1'b0;
      tick(Half);
      if (k >= 4 && k <= 19) word[19-k] = sdo_o;
      sclk_i = 1'b1;
      tick(Half);
    end
    cs_ni = 1'b1;
    tick(Half);
    if (vld_mid) tag++;
  endtask

  task automatic t_reset();
    check("R1 pwr_en", int'(pwr_en_o), 1);
    check("R1 sdo_oe", int'(sdo_oe_o), 0);
    check("R1 data_valid", int'(data_valid_o), 0);
  endtask

  task automatic t_full(input string lbl);
    logic p, o, v; logic [15:0] w; int t0;
    t0 = tag;
    frame(20, p, o, v, w);
    check({lbl, " R9 valid"}, int'(v), 1);
    check({lbl, " R6 oe in frame"}, int'(o), 1);
    check({lbl, " R10 tag word"}, int'(w), t0);
    check({lbl, " R5 pwr after"}, int'(pwr_en_o), 1);
    check({lbl, " R6 oe after"}, int'(sdo_oe_o), 0);
  endtask

  task automatic t_glitch();
    logic p, o, v; logic [15:0] w;
    frame(0, p, o, v, w);
    check("R3 zero edges pwr", int'(pwr_en_o), 1);
    frame(1, p, o, v, w);
    check("R3 one edge pwr", int'(pwr_en_o), 1);
  endtask

  task automatic t_saturate();
    logic p, o, v; logic [15:0] w; int t0;
    t0 = tag;
    frame(34, p, o, v, w);
    check("R2 no wrap pwr", int'(pwr_en_o), 1);
    check("R10 long frame word", int'(w), t0);
    frame(10, p, o, v, w);
    check("R5 ten edges pwr", int'(pwr_en_o), 1);
  endtask

  task automatic t_abort(input int n, input string lbl);
    logic p, o, v; logic [15:0] w;
    frame(n, p, o, v, w);
    check({lbl, " R9 valid before abort"}, int'(v), 1);
    check({lbl, " R4 pwr after"}, int'(pwr_en_o), 0);
    check({lbl, " R4 oe after"}, int'(sdo_oe_o), 0);
  endtask

  task automatic t_wake_glitch();
    logic p, o, v; logic [15:0] w;
    frame(9, p, o, v, w);
    check("R7 pwr during wake", int'(p), 1);
    check("R9 wake frame invalid", int'(v), 0);
    check("R7 back down", int'(pwr_en_o), 0);
    check("R6 oe down", int'(sdo_oe_o), 0);
  endtask

  task automatic t_wake_short();
    logic p, o, v; logic [15:0] w;
    frame(12, p, o, v, w);
    check("R8 short wake pwr", int'(pwr_en_o), 1);
    frame(20, p, o, v, w);
    check("R8 still waking invalid", int'(v), 0);
    check("R10 invalid word zero", int'(w), 0);
    check("R8 wake done pwr", int'(pwr_en_o), 1);
  endtask

  task automatic t_wake_full();
    logic p, o, v; logic [15:0] w;
    frame(20, p, o, v, w);
    check("R9 wake frame invalid", int'(v), 0);
    check("R8 full wake pwr", int'(pwr_en_o), 1);
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(4);
    t_reset();
    t_full("first");
    t_full("second");
    t_glitch();
    t_saturate();
    t_abort(2, "edge2");
    t_wake_glitch();
    t_wake_short();
    t_full("after short wake");
    t_abort(9, "edge9");
    t_wake_full();
    t_full("after full wake");
    summary();
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule